// File: doc/BRIEF.md
# Vector length setting unit

The unit takes a 12-bit control field along with a valid strobe, decodes it, and updates two 6-bit state registers: the maximum vector length (MVL) and the current vector length (VL). The new VL can also be written to an integer register. The unit reads one source count through a combinational read port of a small integer register file. It drives one write port for the write-back. Both the state update and the write-back are committed at the clock edge that ends the strobe cycle.

Field bit 11 selects between two forms. In the compressed form, bits 10:6 hold an immediate, and two 3-bit register specifiers select registers 8 to 15. In the full form, bits 10:6 hold the immediate, bit 5 chooses between write-back and clamp-to-source, and bits 4:0 name any of 32 registers. A separate direct-write port loads VL as a raw 6-bit value. Because storage is 6 bits, a stored 0 is always reported as 64.

Top module: `vlset_unit`

## Requirements
- R1: After reset, `vl_o` and `mvl_o` both read 64 (stored value 0).
- R2: With `field_i[11]`=0 and `field_i[10:0]`=0, a strobe leaves VL and MVL unchanged and does no write-back.
- R3: With `field_i[11]`=0 and a nonzero field, MVL becomes `field_i[10:6]` (0 read as 64). The compressed source specifier s=`field_i[2:0]` reads register 8+s on `rf_raddr_o`. VL becomes min(that value, MVL) when s is nonzero, and becomes MVL when s is zero.
- R4: With `field_i[11]`=0 and a nonzero compressed destination d=`field_i[5:3]`, during the strobe cycle `rf_we_o` is high, `rf_waddr_o` is 8+d, and `rf_wdata_o` is the new VL (64 written as 64).
- R5: With `field_i[11]`=1 and `field_i[5]`=0, MVL becomes the immediate and VL becomes MVL. If `field_i[4:0]` is nonzero, the new VL is written to the register it names.
- R6: With `field_i[11]`=1 and `field_i[5]`=1, MVL becomes the immediate and VL becomes min(register `field_i[4:0]`, MVL). No write-back takes place.
- R7: With `field_i[11]`=1, `field_i[5]`=1 and `field_i[4:0]`=0 (reserved), `illegal_o` is high during the strobe cycle, no write-back occurs, and VL and MVL keep their values.
- R8: When `valid_i` is low, `vl_we_i` loads `vl_wdata_i` into VL. A value of 0 reads back as 64. While `valid_i` is high, the direct write is ignored.
- R9: The clamp compares the full-width source value, so a source of 1000 gives VL equal to MVL.
- R10: With `valid_i` low, the field has no effect: `rf_we_o` and `illegal_o` stay low and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Control field strobe |
| field_i | input | 12 | Vector length control field |
| rf_raddr_o | output | 5 | Source register index |
| rf_rdata_i | input | XLEN | Source register value (combinational read) |
| rf_we_o | output | 1 | Write-back enable |
| rf_waddr_o | output | 5 | Write-back register index |
| rf_wdata_o | output | XLEN | Write-back value (new VL) |
| vl_we_i | input | 1 | Direct VL write enable |
| vl_wdata_i | input | 6 | Direct VL write value |
| illegal_o | output | 1 | Reserved encoding seen on this strobe |
| vl_o | output | 7 | Current VL, 1 to 64 |
| mvl_o | output | 7 | Current MVL, 1 to 64 |

## Verification
The hardest case to reach is a reserved encoding that arrives after the state has been moved away from its reset value. Only then does "unchanged" mean something different from "reset". The vector table first drives clamps and write-backs that leave MVL=31 and VL=7, and then applies the reserved field. A source register of 1000 and an immediate of 0 both lead to the 64 boundary, where the stored value is 0. Those vectors check the clamp and the 64 encoding together.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
  localparam int FIELD_W = 12;
  localparam int IMM_W   = 5;
  localparam int RIDX_W  = 5;
  localparam int CIDX_W  = 3;
  localparam logic [RIDX_W-1:0] CBASE = 5'd8;

  typedef struct packed {
    logic              nop;
    logic              rsvd;
    logic              src_en;
    logic [RIDX_W-1:0] src_addr;
    logic              dst_en;
    logic [RIDX_W-1:0] dst_addr;
    logic [IMM_W-1:0]  imm;
  } vl_dec_t;
endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
  import vlset_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  output vl_dec_t            dec_o
);
  logic              full_form;
  logic [CIDX_W-1:0] c_dst, c_src;
  logic [RIDX_W-1:0] f_reg;

  assign full_form = field_i[11];
  assign c_dst     = field_i[5:3];
  assign c_src     = field_i[2:0];
  assign f_reg     = field_i[4:0];

  always_comb begin
    dec_o          = '0;
    dec_o.imm      = field_i[10:6];
    if (!full_form) begin
      dec_o.nop      = (field_i[10:0] == '0);
      dec_o.src_en   = (c_src != '0);
      dec_o.src_addr = CBASE | {{(RIDX_W-CIDX_W){1'b0}}, c_src};
      dec_o.dst_en   = (c_dst != '0) && !dec_o.nop;
      dec_o.dst_addr = CBASE | {{(RIDX_W-CIDX_W){1'b0}}, c_dst};
    end else if (!field_i[5]) begin
      dec_o.dst_en   = (f_reg != '0);
      dec_o.dst_addr = f_reg;
    end else begin
      dec_o.src_en   = 1'b1;
      dec_o.src_addr = f_reg;
      dec_o.rsvd     = (f_reg == '0);
    end
  end

  always_comb begin
    AST_DEC_EXCL: assert (!(dec_o.rsvd && (dec_o.dst_en || dec_o.nop))); // R7
  end
endmodule

// File: rtl/vlset_calc.sv
module vlset_calc
  import vlset_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VL_W = 6
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             src_en_i,
  input  logic [XLEN-1:0]  src_val_i,
  output logic [VL_W:0]    mvl_new_o,
  output logic [VL_W:0]    vl_new_o
);
  localparam logic [VL_W:0] VL_MAX = {1'b1, {VL_W{1'b0}}};

  logic [XLEN-1:0] mvl_ext;
  logic            clamp;

  assign mvl_new_o = (imm_i == '0) ? VL_MAX : {{(VL_W+1-IMM_W){1'b0}}, imm_i};
  assign mvl_ext   = {{(XLEN-VL_W-1){1'b0}}, mvl_new_o};
  assign clamp     = src_en_i && (src_val_i < mvl_ext);
  assign vl_new_o  = clamp ? src_val_i[VL_W:0] : mvl_new_o;
endmodule

// File: rtl/vlset_state.sv
module vlset_state #(
  parameter int VL_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [VL_W:0]   mvl_new_i,
  input  logic [VL_W:0]   vl_new_i,
  input  logic            dir_we_i,
  input  logic [VL_W-1:0] dir_data_i,
  output logic [VL_W:0]   vl_o,
  output logic [VL_W:0]   mvl_o
);
  logic [VL_W-1:0] vl_q, mvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q  <= '0;
      mvl_q <= '0;
    end else if (upd_i) begin
      vl_q  <= vl_new_i[VL_W-1:0];
      mvl_q <= mvl_new_i[VL_W-1:0];
    end else if (dir_we_i) begin
      vl_q  <= dir_data_i;
    end
  end

  // stored zero stands for the maximum
  assign vl_o  = {(vl_q == '0), vl_q};
  assign mvl_o = {(mvl_q == '0), mvl_q};
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vlset_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VL_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [RIDX_W-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]    rf_rdata_i,
  output logic               rf_we_o,
  output logic [RIDX_W-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  input  logic               vl_we_i,
  input  logic [VL_W-1:0]    vl_wdata_i,
  output logic               illegal_o,
  output logic [VL_W:0]      vl_o,
  output logic [VL_W:0]      mvl_o
);
  localparam logic [VL_W:0] VL_MAX = {1'b1, {VL_W{1'b0}}};

  vl_dec_t       dec;
  logic [VL_W:0] mvl_new, vl_new;
  logic          upd;

  vlset_decode u_decode (
    .field_i (field_i),
    .dec_o   (dec)
  );

  vlset_calc #(.XLEN(XLEN), .VL_W(VL_W)) u_calc (
    .imm_i     (dec.imm),
    .src_en_i  (dec.src_en),
    .src_val_i (rf_rdata_i),
    .mvl_new_o (mvl_new),
    .vl_new_o  (vl_new)
  );

  assign upd        = valid_i && !dec.nop && !dec.rsvd;
  assign rf_raddr_o = dec.src_addr;
  assign rf_we_o    = upd && dec.dst_en;
  assign rf_waddr_o = dec.dst_addr;
  assign rf_wdata_o = {{(XLEN-VL_W-1){1'b0}}, vl_new};
  assign illegal_o  = valid_i && dec.rsvd;

  vlset_state #(.VL_W(VL_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .mvl_new_i  (mvl_new),
    .vl_new_i   (vl_new),
    .dir_we_i   (vl_we_i && !valid_i),
    .dir_data_i (vl_wdata_i),
    .vl_o       (vl_o),
    .mvl_o      (mvl_o)
  );

  AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.nop |=> $stable(vl_o) && $stable(mvl_o)); // R2
  AST_MVL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> mvl_o == (($past(field_i[10:6]) == '0) ? VL_MAX
                      : {{(VL_W+1-IMM_W){1'b0}}, $past(field_i[10:6])})); // R3
  AST_WB_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> vl_o[VL_W-1:0] == $past(rf_wdata_o[VL_W-1:0])); // R4
  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !rf_we_o); // R7
  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(vl_o) && $stable(mvl_o)); // R7
  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_i && !valid_i |=> vl_o[VL_W-1:0] == $past(vl_wdata_i)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !rf_we_o && !illegal_o); // R10
endmodule

// File: tb/vlset_unit_bench.sv
module vlset_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int NVEC = 15;

  logic            clk = 0;
  logic            rst_ni = 0;
  logic            valid_i = 0;
  logic [11:0]     field_i = '0;
  logic [4:0]      rf_raddr_o;
  logic [XLEN-1:0] rf_rdata_i;
  logic            rf_we_o;
  logic [4:0]      rf_waddr_o;
  logic [XLEN-1:0] rf_wdata_o;
  logic            vl_we_i = 0;
  logic [5:0]      vl_wdata_i = '0;
  logic            illegal_o;
  logic [6:0]      vl_o, mvl_o;
  logic [XLEN-1:0] regs [32];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rf_rdata_i = regs[rf_raddr_o];

  vlset_unit u_vlset_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .field_i(field_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .vl_we_i(vl_we_i),
    .vl_wdata_i(vl_wdata_i), .illegal_o(illegal_o), .vl_o(vl_o), .mvl_o(mvl_o)
  );

  function automatic logic [11:0] m0(int imm, int rd, int rs);
    return {1'b0, 5'(imm), 3'(rd), 3'(rs)};
  endfunction
  function automatic logic [11:0] m1(int imm, int b5, int r);
    return {1'b1, 5'(imm), 1'(b5), 5'(r)};
  endfunction
  // {req, field, mvl, vl, we, waddr, wdata, ill}
  function automatic logic [43:0] mk(int req, logic [11:0] f, int mvl, int vl,
                                     int we, int wa, int wd, int ill);
    return {4'(req), f, 7'(mvl), 7'(vl), 1'(we), 5'(wa), 7'(wd), 1'(ill)};
  endfunction

  localparam logic [43:0] VECS [NVEC] = '{
    mk(3, m0(20,0,0), 20, 20, 0, 0, 0, 0),   // R3 no source
    mk(3, m0(25,0,2), 25, 21, 0, 0, 0, 0),   // R3 reg10=21
    mk(4, m0(10,3,1), 10, 10, 1, 11, 10, 0), // R4 reg9=19 clamped
    mk(4, m0(30,5,0), 30, 30, 1, 13, 30, 0), // R4
    mk(2, m0(0,0,0),  30, 30, 0, 0, 0, 0),   // R2 no-op
    mk(9, m0(16,0,3), 16, 16, 0, 0, 0, 0),   // R9 reg11=1000
    mk(3, m0(0,1,7),  64, 31, 1, 9, 31, 0),  // R3 imm 0, reg15=31
    mk(5, m1(12,0,0), 12, 12, 0, 0, 0, 0),   // R5
    mk(5, m1(7,0,20), 7, 7, 1, 20, 7, 0),    // R5
    mk(6, m1(31,1,3), 31, 7, 0, 0, 0, 0),    // R6 reg3=7
    mk(7, m1(5,1,0),  31, 7, 0, 0, 0, 1),    // R7 reserved
    mk(5, m1(0,0,0),  64, 64, 0, 0, 0, 0),   // R5 imm 0
    mk(6, m1(31,1,12), 31, 25, 0, 0, 0, 0),  // R6 reg12=25
    mk(9, m1(0,1,11), 64, 64, 0, 0, 0, 0),   // R9
    mk(4, m0(0,4,0),  64, 64, 1, 12, 64, 0)  // R4 write-back of 64
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) regs[k] = 64'(2*k + 1);
    regs[11] = 64'd1000;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    check("R1 vl after reset", 64'(vl_o), 64);
    check("R1 mvl after reset", 64'(mvl_o), 64);

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [43:0] v = VECS[i];
      automatic string tag = $sformatf("R%0d vec%0d", v[43:40], i);
      @(negedge clk);
      field_i = v[39:28];
      valid_i = 1;
      #1;
      check({tag, " we"}, 64'(rf_we_o), 64'(v[13]));
      check({tag, " illegal"}, 64'(illegal_o), 64'(v[0]));
      if (v[13]) begin
        check({tag, " waddr"}, 64'(rf_waddr_o), 64'(v[12:8]));
        check({tag, " wdata"}, rf_wdata_o, 64'(v[7:1]));
      end
      @(negedge clk);
      valid_i = 0;
      #1;
      check({tag, " mvl"}, 64'(mvl_o), 64'(v[27:21]));
      check({tag, " vl"}, 64'(vl_o), 64'(v[20:14]));
    end

    // R10: field without strobe, state is MVL=64 VL=64
    @(negedge clk);
    field_i = m0(3,2,0);
    #1;
    check("R10 no we when idle", 64'(rf_we_o), 0);
    field_i = m1(5,1,0);
    #1;
    check("R10 no illegal when idle", 64'(illegal_o), 0);
    @(negedge clk);
    #1;
    check("R10 mvl held", 64'(mvl_o), 64);
    check("R10 vl held", 64'(vl_o), 64);

    // R8: direct writes
    vl_we_i = 1; vl_wdata_i = 6'd5;
    @(negedge clk);
    vl_we_i = 0;
    #1;
    check("R8 direct vl=5", 64'(vl_o), 5);
    check("R8 mvl untouched", 64'(mvl_o), 64);
    vl_we_i = 1; vl_wdata_i = 6'd0;
    @(negedge clk);
    vl_we_i = 0;
    #1;
    check("R8 direct 0 reads 64", 64'(vl_o), 64);
    vl_we_i = 1; vl_wdata_i = 6'd3;
    valid_i = 1; field_i = m0(9,0,0);
    @(negedge clk);
    vl_we_i = 0; valid_i = 0;
    #1;
    check("R8 direct ignored under strobe", 64'(vl_o), 9);
    check("R8 mvl from strobe", 64'(mvl_o), 9);

    // R1: reset again after state moved
    rst_ni = 0;
    #1;
    check("R1 vl async reset", 64'(vl_o), 64);
    check("R1 mvl async reset", 64'(mvl_o), 64);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    done = 1;
    summary();
  end
endmodule